// File: doc/BRIEF.md
# Host Register Bank with Byte FIFO and Interrupt

This block is the host-facing register bank of a small bus-controller. A byte-wide host port reaches sixteen register slots. At most slots the read side and the write side are separate storage, so a read can return a value that differs from the last value written there. One slot leads to a byte FIFO that holds at most fifteen bytes. A command engine next to the block reports its results through an event port. The event port loads the interrupt cause, the status bits and the sequence step, and it raises one level interrupt line.

The register slot is the bus address shifted right by `ADDR_SHIFT`. With the default shift of 0, the slot equals the address. When the host asserts write and read in the same cycle, the write uses the port and the read is ignored. Reads are combinational on the current state. Their side effects take place at the clock edge that ends the read cycle.

Top module: `ctlRegBank`

## Requirements
- R1: After reset, irqOut is 0 and every slot reads 0, with two exceptions: slot 8 reads 0x07 and slot 14 reads 0x04. The FIFO is empty.
- R2: Slot 4 reads status. Bit 7 equals irqOut, and bits 6:0 come from the most recent event (bit 4 is terminal count, bits 2:0 are the bus phase).
- R3: An event cycle loads cause (slot 5), status bits 6:0 and sequence step (slot 6, bits 2:0), and irqOut is 1 from the next cycle. If irqOut is already 1, it stays 1 and produces no new edge.
- R4: A read of slot 5 returns the cause value held before the read. From the next cycle, cause reads 0, status bit 4 reads 0, sequence step reads 4 and irqOut is 0.
- R5: When an event falls in the same cycle as a slot 5 read or a slot 0/1 write, the event values win and irqOut stays 1. The read still returns the old cause.
- R6: A write to slot 0 or slot 1 clears status bit 4 and leaves the other status bits unchanged.
- R7: A write to slot 2 appends a byte to the FIFO, and slot 7 reads the fill level (0..15). When 15 bytes are held, the write is dropped and fifoOverrun is 1 for exactly the next cycle.
- R8: When the level is above 0, a read of slot 2 returns the oldest byte (first in, first out), removes it and sets irqOut to 1 from the next cycle. At level 0 the read returns 0 and changes nothing.
- R9: Values written to slot 8 and to slots 11 to 15 read back unchanged.
- R10: Writes to slots 4, 5, 6, 7, 9 and 10 change no read value. Slots 9 and 10 always read 0. Bits 2:0 of the last write to slot 4 drive targetId.
- R11: A write to slot 3 reads back at slot 3 and on cmdByte, and cmdStrobe is 1 for exactly the next cycle. If bit 7 of the written value is set, slots 0 and 1 then read the values last written to them. Until that happens, they keep their previous read values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4+ADDR_SHIFT | Host byte address |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Read data for the addressed slot |
| evtValid | input | 1 | Command engine event strobe |
| evtCause | input | 8 | Cause value (0x08 done, 0x10 service, 0x20 disconnect, 0x80 bus reset) |
| evtStatus | input | 7 | Status bits 6:0 to load |
| evtSeq | input | 3 | Sequence step to load |
| irqOut | output | 1 | Level interrupt |
| targetId | output | 3 | Target ID from slot 4 write side |
| cmdByte | output | 8 | Current command register |
| cmdStrobe | output | 1 | One-cycle pulse after a command write |
| fifoOverrun | output | 1 | One-cycle pulse after a dropped FIFO write |

## Verification
Two updates can hit the same registers in one cycle: a command-engine event and a host access with side effects. These are either a read of the cause slot or a write to a transfer-count slot. The bench provokes both orders on purpose: a directed cycle carries an event and a cause read together, and the random phase drives events alongside host traffic. The outcome is judged at the ports. The read must still return the old cause, and in the following cycle the cause, status and sequence slots must hold the event values with the interrupt still high.

// File: rtl/ctlRegPkg.sv
package ctlRegPkg;
  localparam int REG_IDX_W = 4;

  localparam logic [REG_IDX_W-1:0] IDX_CNT_LO  = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_CNT_MID = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_FIFO    = 4'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CMD     = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_STAT    = 4'd4;
  localparam logic [REG_IDX_W-1:0] IDX_CAUSE   = 4'd5;
  localparam logic [REG_IDX_W-1:0] IDX_SEQ     = 4'd6;
  localparam logic [REG_IDX_W-1:0] IDX_LEVEL   = 4'd7;
  localparam logic [REG_IDX_W-1:0] IDX_CFG1    = 4'd8;
  localparam int HI_BASE = 11;
  localparam int HI_N    = 5;
  localparam int HI_ID   = 3;   // slot 14 holds the chip identifier
  localparam int TC_BIT  = 4;
  localparam logic [2:0] SEQ_AFTER_ACK = 3'd4;

  typedef struct packed {
    logic wrLo;
    logic wrMid;
    logic wrFifo;
    logic wrCmd;
    logic wrBusId;
    logic wrCfg1;
    logic wrHi;
    logic popFifo;
    logic rdCause;
  } strobe_t;
endpackage

// File: rtl/ctlRegCtl.sv
module ctlRegCtl
  import ctlRegPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic                 evtValid,
  input  logic                 fifoNonEmpty,
  output strobe_t              stb,
  output logic                 irqPend
);
  logic rdOk;

  assign rdOk = hostRd && !hostWr;

  always_comb begin
    stb = '0;
    if (hostWr) begin
      unique case (regIdx)
        IDX_CNT_LO:  stb.wrLo    = 1'b1;
        IDX_CNT_MID: stb.wrMid   = 1'b1;
        IDX_FIFO:    stb.wrFifo  = 1'b1;
        IDX_CMD:     stb.wrCmd   = 1'b1;
        IDX_STAT:    stb.wrBusId = 1'b1;
        IDX_CFG1:    stb.wrCfg1  = 1'b1;
        default:     stb.wrHi    = (int'(regIdx) >= HI_BASE);
      endcase
    end
    stb.popFifo = rdOk && (regIdx == IDX_FIFO) && fifoNonEmpty;
    stb.rdCause = rdOk && (regIdx == IDX_CAUSE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqPend <= 1'b0;
    else if (evtValid || stb.popFifo) irqPend <= 1'b1;
    else if (stb.rdCause) irqPend <= 1'b0;
  end
endmodule

// File: rtl/ctlRegData.sv
module ctlRegData
  import ctlRegPkg::*;
#(
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] CHIP_ID    = 8'h04,
  parameter logic [7:0] CFG1_RST   = 8'h07
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [7:0]           wrData,
  input  logic                 evtValid,
  input  logic [7:0]           evtCause,
  input  logic [6:0]           evtStatus,
  input  logic [2:0]           evtSeq,
  input  logic                 irqPend,
  output logic [7:0]           rdData,
  output logic [2:0]           targetId,
  output logic [7:0]           cmdByte,
  output logic                 cmdStrobe,
  output logic                 fifoOverrun,
  output logic                 fifoNonEmpty
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int LVL_W = PTR_W + 1;
  localparam logic [LVL_W-1:0] LVL_CAP = LVL_W'(FIFO_DEPTH - 1);

  logic [7:0] cntLoW, cntMidW, cntLoR, cntMidR;
  logic [7:0] cfg1;
  logic [7:0] cause;
  logic [6:0] status;
  logic [2:0] seqStep;
  logic [7:0] hiReg [HI_N];
  logic [7:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [LVL_W-1:0] level;
  logic atCap, doPush;
  logic [2:0] hiSel;

  assign atCap        = (level == LVL_CAP);
  assign doPush       = stb.wrFifo && !atCap;
  assign fifoNonEmpty = (level != '0);
  assign hiSel        = 3'(regIdx - REG_IDX_W'(HI_BASE));

  // count write/read sides, command, target id, config
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLoW <= '0; cntMidW <= '0; cntLoR <= '0; cntMidR <= '0;
      cmdByte <= '0; cmdStrobe <= 1'b0; targetId <= '0; cfg1 <= CFG1_RST;
      for (int k = 0; k < HI_N; k++) hiReg[k] <= (k == HI_ID) ? CHIP_ID : 8'h00;
    end else begin
      cmdStrobe <= stb.wrCmd;
      if (stb.wrLo)    cntLoW   <= wrData;
      if (stb.wrMid)   cntMidW  <= wrData;
      if (stb.wrBusId) targetId <= wrData[2:0];
      if (stb.wrCfg1)  cfg1     <= wrData;
      if (stb.wrHi)    hiReg[hiSel] <= wrData;
      if (stb.wrCmd) begin
        cmdByte <= wrData;
        if (wrData[7]) begin
          cntLoR  <= cntLoW;
          cntMidR <= cntMidW;
        end
      end
    end
  end

  // cause / status / sequence: event beats host side effects
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cause <= '0; status <= '0; seqStep <= '0;
    end else if (evtValid) begin
      cause <= evtCause; status <= evtStatus; seqStep <= evtSeq;
    end else if (stb.rdCause) begin
      cause <= '0; status[TC_BIT] <= 1'b0; seqStep <= SEQ_AFTER_ACK;
    end else if (stb.wrLo || stb.wrMid) begin
      status[TC_BIT] <= 1'b0;
    end
  end

  // FIFO storage and pointers
  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0; wrPtr <= '0; level <= '0; fifoOverrun <= 1'b0;
    end else begin
      fifoOverrun <= stb.wrFifo && atCap;
      if (doPush) begin
        wrPtr <= wrPtr + 1'b1;
        level <= level + 1'b1;
      end else if (stb.popFifo) begin
        level <= level - 1'b1;
        if (level == LVL_W'(1)) begin
          rdPtr <= '0; wrPtr <= '0;
        end else begin
          rdPtr <= rdPtr + 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (regIdx)
      IDX_CNT_LO:  rdData = cntLoR;
      IDX_CNT_MID: rdData = cntMidR;
      IDX_FIFO:    rdData = fifoNonEmpty ? fifoMem[rdPtr] : 8'h00;
      IDX_CMD:     rdData = cmdByte;
      IDX_STAT:    rdData = {irqPend, status};
      IDX_CAUSE:   rdData = cause;
      IDX_SEQ:     rdData = {5'b0, seqStep};
      IDX_LEVEL:   rdData = 8'(level);
      IDX_CFG1:    rdData = cfg1;
      default:     rdData = (int'(regIdx) >= HI_BASE) ? hiReg[hiSel] : 8'h00;
    endcase
  end
endmodule

// File: rtl/ctlRegBank.sv
module ctlRegBank
  import ctlRegPkg::*;
#(
  parameter int         ADDR_SHIFT = 0,
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] CHIP_ID    = 8'h04,
  parameter logic [7:0] CFG1_RST   = 8'h07,
  localparam int        ADDR_W     = REG_IDX_W + ADDR_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              evtValid,
  input  logic [7:0]        evtCause,
  input  logic [6:0]        evtStatus,
  input  logic [2:0]        evtSeq,
  output logic              irqOut,
  output logic [2:0]        targetId,
  output logic [7:0]        cmdByte,
  output logic              cmdStrobe,
  output logic              fifoOverrun
);
  logic [REG_IDX_W-1:0] regIdx;
  strobe_t stb;
  logic fifoNonEmpty;

  assign regIdx = busAddr[ADDR_W-1:ADDR_SHIFT];

  ctlRegCtl uCtl (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .hostWr(busWrEn), .hostRd(busRdEn),
    .evtValid(evtValid), .fifoNonEmpty(fifoNonEmpty), .stb(stb), .irqPend(irqOut)
  );

  ctlRegData #(.FIFO_DEPTH(FIFO_DEPTH), .CHIP_ID(CHIP_ID), .CFG1_RST(CFG1_RST)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .regIdx(regIdx), .wrData(busWrData),
    .evtValid(evtValid), .evtCause(evtCause), .evtStatus(evtStatus), .evtSeq(evtSeq),
    .irqPend(irqOut), .rdData(busRdData), .targetId(targetId), .cmdByte(cmdByte),
    .cmdStrobe(cmdStrobe), .fifoOverrun(fifoOverrun), .fifoNonEmpty(fifoNonEmpty)
  );
endmodule

// File: rtl/ctlRegBankChk.sv
module ctlRegBankChk #(
  parameter int ADDR_SHIFT = 0,
  localparam int ADDR_W = 4 + ADDR_SHIFT
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [7:0]        busRdData,
  input logic              evtValid,
  input logic              irqOut,
  input logic              cmdStrobe,
  input logic              fifoOverrun
);
  logic [3:0] idx;
  logic hostRd;
  assign idx    = busAddr[ADDR_W-1:ADDR_SHIFT];
  assign hostRd = busRdEn && !busWrEn;

  assert_status_mirrors_irq_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && idx == 4'd4) |-> (busRdData[7] == irqOut));

  assert_event_raises_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> irqOut);

  assert_cause_read_drops_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && idx == 4'd5 && !evtValid) |=> !irqOut);

  assert_overrun_after_fifo_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverrun |-> $past(busWrEn && idx == 4'd2));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(evtValid || (hostRd && idx == 4'd2)));

  assert_cmd_strobe_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(busWrEn && idx == 4'd3));
endmodule

bind ctlRegBank ctlRegBankChk #(.ADDR_SHIFT(ADDR_SHIFT)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busRdData(busRdData), .evtValid(evtValid), .irqOut(irqOut),
  .cmdStrobe(cmdStrobe), .fifoOverrun(fifoOverrun)
);

// File: tb/sim_ctlRegBank.sv
module sim_ctlRegBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic evtValid = 1'b0;
  logic [7:0] evtCause = '0;
  logic [6:0] evtStatus = '0;
  logic [2:0] evtSeq = '0;
  logic irqOut, cmdStrobe, fifoOverrun;
  logic [2:0] targetId;
  logic [7:0] cmdByte;

  int errors = 0, checks = 0;
  bit inReset = 1'b0;

  always #2 clk = ~clk;

  ctlRegBank u0 (.*);

  // bench model
  logic [7:0] mLoW, mMidW, mLoR, mMidR, mCmd, mCause, mCfg1;
  logic [6:0] mStat;
  logic [2:0] mSeq, mBusId;
  logic mIrq, mOvr, mStrobe;
  logic [7:0] mHi [5];
  logic [7:0] mFifo [16];
  int mRp, mWp, mLvl;

  task automatic modelReset();
    mLoW = 0; mMidW = 0; mLoR = 0; mMidR = 0; mCmd = 0; mCause = 0; mCfg1 = 8'h07;
    mStat = 0; mSeq = 0; mBusId = 0; mIrq = 0; mOvr = 0; mStrobe = 0;
    for (int k = 0; k < 5; k++) mHi[k] = (k == 3) ? 8'h04 : 8'h00;
    mRp = 0; mWp = 0; mLvl = 0;
  endtask

  function automatic logic [7:0] expRead(input int idx);
    case (idx)
      0: return mLoR;
      1: return mMidR;
      2: return (mLvl > 0) ? mFifo[mRp] : 8'h00;
      3: return mCmd;
      4: return {mIrq, mStat};
      5: return mCause;
      6: return {5'b0, mSeq};
      7: return 8'(mLvl);
      8: return mCfg1;
      9, 10: return 8'h00;
      default: return mHi[idx-11];
    endcase
  endfunction

  function automatic string tagOf(input int idx);
    case (idx)
      0, 1, 3: return "R11";
      2: return "R8";
      4: return "R2";
      5, 6: return "R4";
      7: return "R7";
      9, 10: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit wr, input bit rd, input int idx, input logic [7:0] d,
                           input bit ev, input logic [7:0] ec, input logic [6:0] es,
                           input logic [2:0] eq);
    bit tcClr = 0, causeRd = 0, popped = 0;
    mOvr = 0; mStrobe = 0;
    if (wr) begin
      case (idx)
        0: begin mLoW = d; tcClr = 1; end
        1: begin mMidW = d; tcClr = 1; end
        2: if (mLvl == 15) mOvr = 1;
           else begin mFifo[mWp] = d; mWp = (mWp + 1) % 16; mLvl++; end
        3: begin mCmd = d; mStrobe = 1; if (d[7]) begin mLoR = mLoW; mMidR = mMidW; end end
        4: mBusId = d[2:0];
        8: mCfg1 = d;
        11, 12, 13, 14, 15: mHi[idx-11] = d;
        default: ;
      endcase
    end else if (rd) begin
      if (idx == 2 && mLvl > 0) begin
        popped = 1; mLvl--;
        if (mLvl == 0) begin mRp = 0; mWp = 0; end else mRp = (mRp + 1) % 16;
      end
      if (idx == 5) causeRd = 1;
    end
    if (ev) begin mCause = ec; mStat = es; mSeq = eq; end
    else if (causeRd) begin mCause = 0; mStat[4] = 0; mSeq = 3'd4; end
    else if (tcClr) mStat[4] = 0;
    if (ev || popped) mIrq = 1; else if (causeRd) mIrq = 0;
  endtask

  task automatic cycle(input bit wr, input bit rd, input int idx, input logic [7:0] d,
                       input bit ev, input logic [7:0] ec, input logic [6:0] es,
                       input logic [2:0] eq);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = 4'(idx); busWrData = d;
    evtValid = ev; evtCause = ec; evtStatus = es; evtSeq = eq;
    #1;
    if (rd && !wr) check(inReset ? "R1" : tagOf(idx), busRdData, expRead(idx));
    check("R3 irq", irqOut, mIrq);
    check("R7 overrun", fifoOverrun, mOvr);
    check("R11 strobe", cmdStrobe, mStrobe);
    check("R10 targetId", targetId, mBusId);
    check("R11 cmdByte", cmdByte, mCmd);
    @(posedge clk);
    modelStep(wr, rd, idx, d, ev, ec, es, eq);
  endtask

  task automatic rdSlot(input int idx); cycle(0, 1, idx, 8'h00, 0, 0, 0, 0); endtask
  task automatic wrSlot(input int idx, input logic [7:0] d); cycle(1, 0, idx, d, 0, 0, 0, 0); endtask
  task automatic evt(input logic [7:0] c, input logic [6:0] s, input logic [2:0] q);
    cycle(0, 0, 0, 8'h00, 1, c, s, q);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset values of every slot
    inReset = 1'b1;
    check("R1 irq", irqOut, 0);
    for (int i = 0; i < 16; i++) if (i != 2 && i != 5) rdSlot(i);
    inReset = 1'b0;

    // R10: write-only slots leave reads untouched
    for (int i = 4; i <= 10; i++) if (i != 8) wrSlot(i, 8'hA5 ^ 8'(i));
    for (int i = 4; i <= 10; i++) rdSlot(i);

    // R9: readable configuration
    wrSlot(8, 8'h3C); wrSlot(14, 8'h91); wrSlot(11, 8'h5A);
    rdSlot(8); rdSlot(14); rdSlot(11);

    // R11: counts reload only on a command with bit 7
    wrSlot(0, 8'h12); wrSlot(1, 8'h34);
    rdSlot(0); rdSlot(1);
    wrSlot(3, 8'h10); rdSlot(0);
    wrSlot(3, 8'h90); rdSlot(0); rdSlot(1); rdSlot(3);

    // R3/R2/R4: event, double event, status and cause acknowledge
    evt(8'h18, 7'h13, 3'd2);
    evt(8'h10, 7'h11, 3'd3);
    rdSlot(4); rdSlot(6);
    rdSlot(5); rdSlot(5); rdSlot(4); rdSlot(6);

    // R6: count write clears only the terminal-count bit
    evt(8'h08, 7'h17, 3'd1);
    wrSlot(1, 8'h00); rdSlot(4);

    // R5: event together with a cause read, and with a count write
    cycle(0, 1, 5, 8'h00, 1, 8'h20, 7'h56, 3'd5);
    rdSlot(5); rdSlot(4); rdSlot(6);
    cycle(1, 0, 0, 8'h77, 1, 8'h80, 7'h10, 3'd6);
    rdSlot(4);
    rdSlot(5);

    // R7/R8: fill past the cap, then drain past empty
    for (int i = 0; i < 17; i++) wrSlot(2, 8'(8'hC0 + i));
    rdSlot(7);
    for (int i = 0; i < 17; i++) rdSlot(2);
    rdSlot(7); rdSlot(5);
    wrSlot(2, 8'hEE); rdSlot(2); rdSlot(2);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      int idx = ($urandom % 3 == 0) ? 2 : (($urandom % 4 == 0) ? 5 : int'($urandom % 16));
      bit ev = ($urandom % 10 == 0);
      cycle(r < 45, (r >= 45) && (r < 90), idx, 8'($urandom), ev,
            8'($urandom), 7'($urandom), 3'($urandom));
    end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule